// File: doc/BRIEF.md
# Quiesce-and-Gate Low-Power Controller

This controller moves a core clock domain into a low-power state and brings it back out. There are two ways in. The pipeline can issue a one-cycle wait-for-interrupt command. The system can instead raise a level clock-stop request.

In both cases the controller first waits for a busy vector to drain. The vector has one bit per activity class: load/store, instruction fetch, L2, bus, SIMD and trace transfer. Any bit may be high, and all bits are equivalent. At entry the controller also fires a one-cycle strobe that aborts prefetch-engine activity, because that activity is not waited for.

Once the domain is quiet, the controller raises either a standby output (command entry) or a stop acknowledge (request entry). A fixed number of cycles later it closes the enable of an external clock-gate cell. It wakes on an active-low IRQ or FIQ, or on a halting debug event while a debug-keep-clock input is high. In request mode it wakes when the request falls. When debug-keep-clock is high, the handshakes still assert but the gate stays open (idle instead of low power).

The controller runs on the free-running clock, so it sees wake inputs while the gate is closed. Every pin is a plain control level or strobe. There is no data path, so no valid/ready interface exists.

Top module: `lp_quiesce_ctrl`

## Requirements
- R1: After reset, `standby`, `stop_ack` and `pf_abort` are low and `gate_en` is high.
- R2: From the running state, `stop_req` high at a clock edge starts a request entry, and a `wfi_cmd` pulse starts a command entry. If both are high at the same edge, the request entry wins. `standby` and `stop_ack` are never high together.
- R3: `pf_abort` is high for exactly the one cycle that follows the edge at which an entry trigger is accepted.
- R4: The handshake output does not rise while any `busy` bit is high. For a command entry, `standby` rises at the first edge at which all `busy` bits are sampled low.
- R5: For a request entry, `stop_ack` rises at the later of two edges: the 20th edge after the edge that accepted the request, and the first edge at which `busy` is sampled all-low. There is no upper bound on this delay.
- R6: Unless `dbg_keep_clk` is high, `gate_en` falls on the falling clock edge after the 7th rising edge following the handshake rise. The gate is therefore closed within 8 cycles of the handshake rise.
- R7: In a command entry, a wake event takes the controller out of low power. A wake event is `irq_n` low, `fiq_n` low, or `dbg_halt` high with `dbg_keep_clk` high. The event is sampled at edge E. `gate_en` reopens on the following falling edge, and `standby` falls at edge E+1.
- R8: In a request entry, `stop_req` sampled low at edge E reopens the gate on the following falling edge. `stop_ack` falls at edge E+1, which is within 8 cycles.
- R9: While `dbg_keep_clk` is high, `gate_en` stays high. `standby` and `stop_ack` still assert as normal.
- R10: A wake event that arrives while a command entry is still draining returns the controller to the running state without raising `standby`.
- R11: In a command entry, `dbg_halt` with `dbg_keep_clk` low is not a wake event. `standby` stays high.
- R12: In a request entry, `irq_n`, `fiq_n` and `wfi_cmd` have no effect. `stop_ack` stays high until `stop_req` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wfi_cmd | input | 1 | One-cycle wait-for-interrupt command |
| stop_req | input | 1 | Level clock-stop request |
| busy | input | NUM_BUSY | Outstanding-activity flags, one per class |
| irq_n | input | 1 | Active-low interrupt |
| fiq_n | input | 1 | Active-low fast interrupt |
| dbg_halt | input | 1 | Halting debug event |
| dbg_keep_clk | input | 1 | Keep clock running (idle-only entry) |
| pf_abort | output | 1 | One-cycle prefetch-abort strobe |
| standby | output | 1 | Command-entry handshake |
| stop_ack | output | 1 | Request-entry acknowledge |
| gate_en | output | 1 | Clock-gate enable, changes on falling edge |

## Verification
The hardest case to reach is a request entry in which draining finishes after the 20-cycle minimum, rather than before it. A second hard case is a wake that lands while a command entry is still draining. The stimulus holds one `busy` bit high across 30 edges under a request and then releases it. In a separate command entry, it pulses `irq_n` while `busy` is still high and then releases `busy`. A behavioural reference model, compared on every cycle, checks that neither case raises a handshake early and that neither raises a stray one.

// File: rtl/lpq_pkg.sv
package lpq_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_DRAIN, ST_WAIT_MIN, ST_ACK_GATING, ST_GATED, ST_EXIT
  } lpq_state_e;

  typedef enum logic {
    SRC_CMD, SRC_REQ
  } lpq_src_e;
endpackage

// File: rtl/lpq_drain_mon.sv
module lpq_drain_mon #(
  parameter int NUM_BUSY = 6
) (
  input  logic [NUM_BUSY-1:0] busy,
  output logic                quiet
);
  logic [NUM_BUSY:0] chain;
  assign chain[0] = 1'b1;
  for (genvar g = 0; g < NUM_BUSY; g++) begin : g_chain
    assign chain[g+1] = chain[g] & ~busy[g];
  end
  assign quiet = chain[NUM_BUSY];
endmodule

// File: rtl/lpq_sat_cnt.sv
module lpq_sat_cnt #(
  parameter int W   = 5,
  parameter int MAX = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] LIM = W'(MAX);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (inc && cnt != LIM) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lpq_fsm.sv
module lpq_fsm
  import lpq_pkg::*;
#(
  parameter int MIN_REQ_CYC    = 20,
  parameter int GATE_CLOSE_CYC = 8,
  parameter int CW             = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wfi_cmd,
  input  logic          stop_req,
  input  logic          quiet,
  input  logic          wake,
  input  logic [CW-1:0] cnt,
  output lpq_state_e    state,
  output lpq_src_e      src,
  output logic          cnt_clr,
  output logic          pf_abort
);
  localparam logic [CW-1:0] MIN_LIM   = CW'(MIN_REQ_CYC - 1);
  localparam logic [CW-1:0] CLOSE_LIM = CW'(GATE_CLOSE_CYC - 2);

  lpq_state_e nxt;
  lpq_src_e   nsrc;
  logic       min_met, close_met, leave, take;

  assign min_met   = cnt >= MIN_LIM;
  assign close_met = cnt >= CLOSE_LIM;
  assign leave     = (src == SRC_CMD) ? wake : !stop_req;
  assign take      = (state == ST_RUN) && (stop_req || wfi_cmd);

  always_comb begin
    nxt     = state;
    nsrc    = src;
    cnt_clr = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (take) begin
          nxt     = ST_DRAIN;
          nsrc    = stop_req ? SRC_REQ : SRC_CMD;
          cnt_clr = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (src == SRC_CMD) begin
          if (wake) nxt = ST_RUN;
          else if (quiet) begin
            nxt     = ST_ACK_GATING;
            cnt_clr = 1'b1;
          end
        end else if (quiet) begin
          if (min_met) begin
            nxt     = ST_ACK_GATING;
            cnt_clr = 1'b1;
          end else begin
            nxt = ST_WAIT_MIN;
          end
        end
      end
      ST_WAIT_MIN: begin
        if (min_met) begin
          nxt     = ST_ACK_GATING;
          cnt_clr = 1'b1;
        end
      end
      ST_ACK_GATING: begin
        if (leave)          nxt = ST_EXIT;
        else if (close_met) nxt = ST_GATED;
      end
      ST_GATED: if (leave) nxt = ST_EXIT;
      ST_EXIT:  nxt = ST_RUN;
      default:  nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      src      <= SRC_CMD;
      pf_abort <= 1'b0;
    end else begin
      state    <= nxt;
      src      <= nsrc;
      pf_abort <= take;
    end
  end
endmodule

// File: rtl/lpq_gate_ctl.sv
module lpq_gate_ctl
  import lpq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lpq_state_e state,
  input  logic       dbg_keep_clk,
  output logic       gate_en
);
  logic want_run;
  assign want_run = !((state == ST_GATED) && !dbg_keep_clk);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_en <= 1'b1;
    else        gate_en <= want_run;
  end
endmodule

// File: rtl/lp_quiesce_ctrl.sv
module lp_quiesce_ctrl
  import lpq_pkg::*;
#(
  parameter int NUM_BUSY       = 6,
  parameter int MIN_REQ_CYC    = 20,
  parameter int GATE_CLOSE_CYC = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wfi_cmd,
  input  logic                stop_req,
  input  logic [NUM_BUSY-1:0] busy,
  input  logic                irq_n,
  input  logic                fiq_n,
  input  logic                dbg_halt,
  input  logic                dbg_keep_clk,
  output logic                pf_abort,
  output logic                standby,
  output logic                stop_ack,
  output logic                gate_en
);
  localparam int CNT_MAX = (MIN_REQ_CYC - 1 > GATE_CLOSE_CYC - 2) ?
                           MIN_REQ_CYC - 1 : GATE_CLOSE_CYC - 2;
  localparam int CW = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX + 1);

  logic          quiet, wake, cnt_clr, hs_on;
  logic [CW-1:0] cnt;
  lpq_state_e    state;
  lpq_src_e      src;

  assign wake = !irq_n || !fiq_n || (dbg_halt && dbg_keep_clk);

  lpq_drain_mon #(.NUM_BUSY(NUM_BUSY)) u_drain (.busy(busy), .quiet(quiet));

  lpq_sat_cnt #(.W(CW), .MAX(CNT_MAX)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(1'b1), .cnt(cnt)
  );

  lpq_fsm #(.MIN_REQ_CYC(MIN_REQ_CYC), .GATE_CLOSE_CYC(GATE_CLOSE_CYC), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wfi_cmd(wfi_cmd), .stop_req(stop_req),
    .quiet(quiet), .wake(wake), .cnt(cnt), .state(state), .src(src),
    .cnt_clr(cnt_clr), .pf_abort(pf_abort)
  );

  lpq_gate_ctl u_gate (
    .clk(clk), .rst_n(rst_n), .state(state), .dbg_keep_clk(dbg_keep_clk), .gate_en(gate_en)
  );

  assign hs_on    = (state == ST_ACK_GATING) || (state == ST_GATED) || (state == ST_EXIT);
  assign standby  = hs_on && (src == SRC_CMD);
  assign stop_ack = hs_on && (src == SRC_REQ);
endmodule

// File: rtl/lpq_checker.sv
module lpq_checker #(
  parameter int NUM_BUSY       = 6,
  parameter int MIN_REQ_CYC    = 20,
  parameter int GATE_CLOSE_CYC = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                stop_req,
  input logic [NUM_BUSY-1:0] busy,
  input logic                dbg_keep_clk,
  input logic                pf_abort,
  input logic                standby,
  input logic                stop_ack,
  input logic                gate_en
);
  localparam int KW = $clog2(MIN_REQ_CYC + GATE_CLOSE_CYC + 2) + 1;
  localparam logic [KW-1:0] KMAX = '1;

  logic [KW-1:0] req_run, drop_run, open_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_run  <= '0;
      drop_run <= '0;
      open_run <= '0;
    end else begin
      req_run  <= !stop_req ? '0 : (req_run == KMAX ? req_run : req_run + 1'b1);
      drop_run <= !(stop_ack && !stop_req) ? '0 : (drop_run == KMAX ? drop_run : drop_run + 1'b1);
      open_run <= !((stop_ack || standby) && gate_en && !dbg_keep_clk) ? '0 :
                  (open_run == KMAX ? open_run : open_run + 1'b1);
    end
  end

  assert_excl_R2: assert property (@(posedge clk) disable iff (!rst_n) !(standby && stop_ack));
  assert_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n) pf_abort |=> !pf_abort);
  assert_drained_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby) |-> $past(busy) == '0);
  assert_min_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_ack) |-> req_run >= KW'(MIN_REQ_CYC));
  assert_close_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    open_run <= KW'(GATE_CLOSE_CYC));
  assert_closed_only_hs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |-> (standby || stop_ack));
  assert_ack_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_run <= KW'(GATE_CLOSE_CYC));
  assert_keep_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_keep_clk && $past(dbg_keep_clk)) |-> gate_en);
endmodule

bind lp_quiesce_ctrl lpq_checker #(
  .NUM_BUSY(NUM_BUSY), .MIN_REQ_CYC(MIN_REQ_CYC), .GATE_CLOSE_CYC(GATE_CLOSE_CYC)
) u_lpq_chk (.*);

// File: tb/lp_quiesce_ctrl_bench.sv
module lp_quiesce_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int NB = 6;
  localparam int MINC = 20;
  localparam int GCC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wfi_cmd = 1'b0, stop_req = 1'b0, irq_n = 1'b1, fiq_n = 1'b1;
  logic dbg_halt = 1'b0, dbg_keep_clk = 1'b0;
  logic [NB-1:0] busy = '0;
  logic pf_abort, standby, stop_ack, gate_en;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  lp_quiesce_ctrl #(.NUM_BUSY(NB), .MIN_REQ_CYC(MINC), .GATE_CLOSE_CYC(GCC)) u_lp_quiesce_ctrl (
    .clk(clk), .rst_n(rst_n), .wfi_cmd(wfi_cmd), .stop_req(stop_req), .busy(busy),
    .irq_n(irq_n), .fiq_n(fiq_n), .dbg_halt(dbg_halt), .dbg_keep_clk(dbg_keep_clk),
    .pf_abort(pf_abort), .standby(standby), .stop_ack(stop_ack), .gate_en(gate_en)
  );

  // Reference model: phase 0 running, 1 draining, 2 waiting out minimum,
  // 3 handshake up and closing, 4 closed, 5 leaving.
  int  ph = 0, since_req = 0, since_hs = 0;
  bit  by_req = 0, m_pf = 0, m_gate = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; by_req = 0; m_pf = 0; since_req = 0; since_hs = 0;
    end else begin
      automatic bit wk = !irq_n || !fiq_n || (dbg_halt && dbg_keep_clk);
      automatic bit qt = (busy == '0);
      automatic bit go = by_req ? !stop_req : wk;
      m_pf = 0;
      case (ph)
        0: if (stop_req || wfi_cmd) begin
             ph = 1; by_req = stop_req; m_pf = 1; since_req = 0;
           end
        1: begin
             if (!by_req) begin
               if (wk) ph = 0;
               else if (qt) begin ph = 3; since_hs = 0; end
             end else begin
               if (qt) begin
                 if (since_req >= MINC - 1) begin ph = 3; since_hs = 0; end
                 else ph = 2;
               end
               since_req++;
             end
           end
        2: begin
             if (since_req >= MINC - 1) begin ph = 3; since_hs = 0; end
             since_req++;
           end
        3: begin
             if (go) ph = 5;
             else if (since_hs >= GCC - 2) ph = 4;
             since_hs++;
           end
        4: if (go) ph = 5;
        default: ph = 0;
      endcase
    end
  end

  always @(negedge clk) m_gate = !rst_n ? 1'b1 : !(ph == 4 && !dbg_keep_clk);

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n && !done) begin
      chk(pf_abort, m_pf, "R3 pf_abort");
      chk(standby, (!by_req && ph >= 3), "R4 standby");
      chk(stop_ack, (by_req && ph >= 3), "R5 stop_ack");
      chk(gate_en, m_gate, "R6 gate_en");
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    step(3);
    chk(standby, 0, "R1 standby"); chk(stop_ack, 0, "R1 stop_ack");
    chk(pf_abort, 0, "R1 pf_abort"); chk(gate_en, 1, "R1 gate_en");
    rst_n = 1'b1;
    step(2);

    // command entry with staged drain, IRQ wake
    wfi_cmd = 1; busy = 6'b101001; step(1); wfi_cmd = 0;
    chk(pf_abort, 1, "R3 strobe");
    step(1); chk(pf_abort, 0, "R3 strobe end");
    step(4); chk(standby, 0, "R4 busy blocks");
    busy = 6'b000001; step(3); busy = '0; step(1);
    chk(standby, 1, "R4 rise on drain");
    step(10); chk(gate_en, 0, "R6 closed");
    irq_n = 0; step(1); irq_n = 1; chk(standby, 1, "R7 exit cycle");
    step(1); chk(standby, 0, "R7 irq wake"); chk(gate_en, 1, "R7 reopen");
    step(3);

    // debug halt without keep-clock ignored, then FIQ wakes
    wfi_cmd = 1; step(1); wfi_cmd = 0; step(12);
    dbg_halt = 1; step(1); dbg_halt = 0; step(3);
    chk(standby, 1, "R11 halt ignored"); chk(gate_en, 0, "R11 still closed");
    fiq_n = 0; step(1); fiq_n = 1; step(2);
    chk(standby, 0, "R7 fiq wake");
    step(2);

    // wake during drain
    wfi_cmd = 1; busy = 6'b010000; step(1); wfi_cmd = 0; step(2);
    irq_n = 0; step(1); irq_n = 1; busy = '0; step(6);
    chk(standby, 0, "R10 no standby"); chk(gate_en, 1, "R10 open");
    step(2);

    // keep-clock: idle only, halt wakes
    dbg_keep_clk = 1; wfi_cmd = 1; step(1); wfi_cmd = 0; step(15);
    chk(standby, 1, "R9 standby"); chk(gate_en, 1, "R9 gate open");
    dbg_halt = 1; step(1); dbg_halt = 0; step(2);
    chk(standby, 0, "R7 halt wake");
    dbg_keep_clk = 0; step(2);

    // request entry, already quiet: minimum wait
    stop_req = 1; step(20); chk(stop_ack, 0, "R5 too early");
    step(1); chk(stop_ack, 1, "R5 at minimum");
    step(10); chk(gate_en, 0, "R6 req closed");
    irq_n = 0; wfi_cmd = 1; step(1); irq_n = 1; wfi_cmd = 0; step(2);
    chk(stop_ack, 1, "R12 irq ignored"); chk(standby, 0, "R12 cmd ignored");
    stop_req = 0; step(1); chk(stop_ack, 1, "R8 exit cycle");
    step(1); chk(stop_ack, 0, "R8 ack drop"); chk(gate_en, 1, "R8 reopen");
    step(3);

    // request entry with slow drain past the minimum
    busy = 6'b000100; stop_req = 1; step(30);
    chk(stop_ack, 0, "R5 busy blocks");
    busy = '0; step(1); chk(stop_ack, 1, "R5 rise on drain");
    stop_req = 0; step(3); chk(stop_ack, 0, "R8 early drop");
    step(2);

    // simultaneous triggers: request wins
    stop_req = 1; wfi_cmd = 1; step(1); wfi_cmd = 0; step(25);
    chk(stop_ack, 1, "R2 req wins"); chk(standby, 0, "R2 no standby");
    stop_req = 0; step(3);

    // keep-clock with request
    dbg_keep_clk = 1; stop_req = 1; step(30);
    chk(stop_ack, 1, "R9 ack"); chk(gate_en, 1, "R9 req open");
    stop_req = 0; step(3); dbg_keep_clk = 0; step(3);

    finish_up();
  end
endmodule